// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits between a serial receiver's deserializer and a host register interface. Every character the deserializer delivers comes with three error indications: a break, a missing stop bit (framing) and a parity mismatch. The block stores each character together with its own three indications in a first-in first-out queue of `DEPTH` entries (64 by default). It shows the host the character at the head of the queue and an 8-bit line status word.

The status word reports the error indications of the head character, so the host reads status first and then pops the data. It also says whether the queue holds data and whether a flagged character is present anywhere in the queue. For that last bit the block keeps a count of flagged entries rather than scanning the storage. A sticky overrun indication records characters that arrived while the queue was full and were discarded; reading status clears it. Two bits pass the transmitter's holding-register-empty and shift-register-idle conditions through.

Top module: `rx_status_tracker`

## Requirements
- R1: A write strobe while the queue holds fewer than DEPTH (64) characters appends the byte and its three error indications at the tail. `rx_data` always shows the head byte, and reads 0x00 when the queue is empty.
- R2: A character written with its break indication set is stored as 0x00, whatever byte accompanies it.
- R3: A pop removes the head character. A pop of an empty queue changes nothing: the queue stays empty and `rx_data` stays 0x00.
- R4: Status bit 0 is 1 exactly when the queue holds at least one character.
- R5: Status bits 4, 3 and 2 are the break, framing and parity indications of the head character, and are 0 when the queue is empty.
- R6: Status bit 7 is 1 exactly when at least one stored character has any error indication set. This also holds when a push and a pop happen in the same cycle.
- R7: A write strobe while the queue holds DEPTH characters discards the character, even if a pop happens in the same cycle, and sets status bit 1 after that edge.
- R8: Status bit 1 is sticky. A status read clears it at the next edge, unless a discarded write happens in the same cycle, in which case it stays 1.
- R9: Status bit 5 equals `tx_hold_empty`. Status bit 6 equals `tx_hold_empty` AND `tx_shift_idle`.
- R10: After reset the queue is empty and status bits 7, 4, 3, 2, 1 and 0 are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_wr | input | 1 | Character strobe from the deserializer |
| rx_byte | input | 8 | Received byte |
| rx_brk | input | 1 | Break indication of the character |
| rx_frm | input | 1 | Framing error indication of the character |
| rx_par | input | 1 | Parity error indication of the character |
| host_pop | input | 1 | Remove the head character |
| host_stat_rd | input | 1 | Status read, clears the overrun bit |
| tx_hold_empty | input | 1 | Transmit holding register or queue is empty |
| tx_shift_idle | input | 1 | Transmit shift register is empty |
| rx_data | output | 8 | Head character, 0x00 when empty |
| line_status | output | 8 | Status word, bit map as in R4 to R9 |

## Verification
The hardest case to reach is the full queue: a write and a pop arriving in the same cycle, with a status read in that cycle too, while flagged entries lie both at the head and deep in the queue. The stimulus first fills all 64 places with a sparse mix of flagged characters. It then issues writes with and without simultaneous pops and reads at that boundary. Finally it drains the queue with reads interleaved, so the error-anywhere bit has to fall exactly when the last flagged entry leaves.

// File: rtl/rxst_pkg.sv
package rxst_pkg;

    // One stored character with its own error indications
    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rxst_fifo.sv
module rxst_fifo
    import rxst_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  rx_entry_t                    push_entry,
    input  logic                         pop,
    output rx_entry_t                    head,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] lvl;
    } ptr_t;

    ptr_t      ptr_d, ptr_q;
    rx_entry_t mem [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (push) begin
            ptr_d.wr = (ptr_q.wr == AW'(DEPTH - 1)) ? '0 : ptr_q.wr + 1'b1;
        end
        if (pop) begin
            ptr_d.rd = (ptr_q.rd == AW'(DEPTH - 1)) ? '0 : ptr_q.rd + 1'b1;
        end
        ptr_d.lvl = ptr_q.lvl + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[ptr_q.wr] <= push_entry;
        end
    end

    assign empty = (ptr_q.lvl == '0);
    assign full  = (ptr_q.lvl == CW'(DEPTH));
    assign level = ptr_q.lvl;
    assign head  = empty ? '0 : mem[ptr_q.rd];

    // R7
    lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    // R7
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R3
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);

endmodule

// File: rtl/rxst_errcnt.sv
module rxst_errcnt #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         inc,
    input  logic                         dec,
    output logic                         any_err,
    output logic [$clog2(DEPTH+1)-1:0]   err_cnt
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.cnt = cnt_q.cnt + CW'(inc) - CW'(dec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign err_cnt = cnt_q.cnt;
    assign any_err = (cnt_q.cnt != '0);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |-> (err_cnt != '0));

endmodule

// File: rtl/rx_status_tracker.sv
module rx_status_tracker
    import rxst_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_wr,
    input  logic [7:0] rx_byte,
    input  logic       rx_brk,
    input  logic       rx_frm,
    input  logic       rx_par,
    input  logic       host_pop,
    input  logic       host_stat_rd,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_idle,
    output logic [7:0] rx_data,
    output logic [7:0] line_status
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic ovr;
    } top_st_t;

    top_st_t   st_d, st_q;
    rx_entry_t head, wr_entry;
    logic      empty, full, push_ok, pop_ok, any_err, wr_flagged, head_flagged;
    logic [CW-1:0] level, err_cnt;

    assign wr_flagged   = rx_brk | rx_frm | rx_par;
    assign head_flagged = head.brk | head.frm | head.par;
    assign push_ok      = rx_wr & ~full;
    assign pop_ok       = host_pop & ~empty;

    always_comb begin
        wr_entry.brk  = rx_brk;
        wr_entry.frm  = rx_frm;
        wr_entry.par  = rx_par;
        wr_entry.data = rx_brk ? 8'h00 : rx_byte;
    end

    rxst_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_ok),
        .push_entry (wr_entry),
        .pop        (pop_ok),
        .head       (head),
        .empty      (empty),
        .full       (full),
        .level      (level)
    );

    rxst_errcnt #(.DEPTH(DEPTH)) errcnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (push_ok & wr_flagged),
        .dec     (pop_ok & head_flagged),
        .any_err (any_err),
        .err_cnt (err_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (rx_wr && full) begin
            st_d.ovr = 1'b1;
        end else if (host_stat_rd) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_data     = head.data;
    assign line_status = {any_err,
                          tx_hold_empty & tx_shift_idle,
                          tx_hold_empty,
                          head.brk, head.frm, head.par,
                          st_q.ovr,
                          ~empty};

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr && full) |=> line_status[1]);
    // R8
    ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stat_rd && !(rx_wr && full)) |=> !line_status[1]);
    // R6
    err_within_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= level);
    // R6
    empty_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_status[0] |-> !line_status[7]);
    // R5
    empty_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_status[0] |-> (line_status[4:2] == 3'b000));

endmodule

// File: tb/rx_status_tracker_tb_top.sv
`timescale 1ns/1ps
module rx_status_tracker_tb_top;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_wr = 1'b0, rx_brk = 1'b0, rx_frm = 1'b0, rx_par = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       host_pop = 1'b0, host_stat_rd = 1'b0;
    logic       tx_hold_empty = 1'b0, tx_shift_idle = 1'b0;
    logic [7:0] rx_data, line_status;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [10:0] mq[$];
    bit          ovr_m = 1'b0;

    always #2.5 clk = ~clk;

    rx_status_tracker #(.DEPTH(DEPTH)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_wr         (rx_wr),
        .rx_byte       (rx_byte),
        .rx_brk        (rx_brk),
        .rx_frm        (rx_frm),
        .rx_par        (rx_par),
        .host_pop      (host_pop),
        .host_stat_rd  (host_stat_rd),
        .tx_hold_empty (tx_hold_empty),
        .tx_shift_idle (tx_shift_idle),
        .rx_data       (rx_data),
        .line_status   (line_status)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual 0x%02h expected 0x%02h", tag, $time, act, exp);
        end
    endtask

    // Compare every output against the behavioural model
    task automatic compare_all();
        logic [7:0] exp_data;
        logic [2:0] exp_flags;
        bit         any;
        any = 1'b0;
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) any = 1'b1;
        exp_data  = (mq.size() > 0) ? mq[0][7:0]  : 8'h00;
        exp_flags = (mq.size() > 0) ? mq[0][10:8] : 3'b000;
        if (mq.size() > 0 && mq[0][10]) check("R2 head byte of break", rx_data, exp_data);
        else                            check("R1 head byte", rx_data, exp_data);
        check("R4 data ready", {7'd0, line_status[0]}, {7'd0, mq.size() > 0});
        check("R5 head flags", {5'd0, line_status[4:2]}, {5'd0, exp_flags});
        check("R6 error anywhere", {7'd0, line_status[7]}, {7'd0, any});
        check("R8 overrun", {7'd0, line_status[1]}, {7'd0, ovr_m});
        check("R9 tx bits", {6'd0, line_status[6:5]},
              {6'd0, tx_hold_empty & tx_shift_idle, tx_hold_empty});
    endtask

    // Drive one cycle, advance the model at the edge, compare mid-cycle
    task automatic step(input bit wr, input logic [7:0] b, input bit brk, input bit frm,
                        input bit par, input bit pop, input bit srd);
        bit full_m;
        rx_wr = wr; rx_byte = b; rx_brk = brk; rx_frm = frm; rx_par = par;
        host_pop = pop; host_stat_rd = srd;
        @(posedge clk);
        full_m = (mq.size() == DEPTH);
        if (wr && full_m) ovr_m = 1'b1;
        else if (srd)     ovr_m = 1'b0;
        if (pop && mq.size() > 0) void'(mq.pop_front());
        if (wr && !full_m) mq.push_back({brk, frm, par, brk ? 8'h00 : b});
        @(negedge clk);
        compare_all();
    endtask

    task automatic rand_push(input bit pop, input bit srd);
        bit flg;
        flg = ($urandom_range(0, 7) == 0);
        step(1'b1, 8'($urandom), flg && ($urandom_range(0, 2) == 0),
             flg && ($urandom_range(0, 1) == 0), flg && ($urandom_range(0, 1) == 0),
             pop, srd);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state with both tx inputs low
        check("R10 reset status", line_status, 8'h00);
        check("R10 reset data", rx_data, 8'h00);

        // R3: pop of an empty queue
        step(1'b0, 8'h00, 0, 0, 0, 1'b1, 1'b0);
        check("R3 empty after pop", {7'd0, line_status[0]}, 8'h00);
        check("R3 data after pop", rx_data, 8'h00);

        // Directed characters, break with nonzero byte
        tx_hold_empty = 1'b1;
        step(1'b1, 8'hA5, 0, 0, 0, 0, 0);
        step(1'b1, 8'h7E, 1, 0, 0, 0, 0);
        step(1'b1, 8'h3C, 0, 1, 0, 0, 0);
        step(1'b1, 8'h11, 0, 0, 1, 0, 0);
        step(1'b1, 8'h22, 0, 0, 0, 0, 0);
        tx_shift_idle = 1'b1;
        step(1'b0, 8'h00, 0, 0, 0, 1, 1);
        check("R2 break stored as zero", rx_data, 8'h00);
        check("R5 break flag at head", {5'd0, line_status[4:2]}, 8'h04);
        repeat (5) step(1'b0, 8'h00, 0, 0, 0, 1, 1);

        // Fill to full with sparse errors
        tx_shift_idle = 1'b0;
        repeat (DEPTH) rand_push(1'b0, 1'b0);
        step(1'b1, 8'h55, 0, 0, 1, 0, 0);
        check("R7 overrun set", {7'd0, line_status[1]}, 8'h01);
        // push with pop at full: discarded, and read with overrun keeps it
        step(1'b1, 8'h66, 0, 0, 0, 1, 1);
        check("R7 push at full discarded", {7'd0, line_status[1]}, 8'h01);
        step(1'b0, 8'h00, 0, 0, 0, 0, 1);
        check("R8 overrun cleared", {7'd0, line_status[1]}, 8'h00);
        step(1'b1, 8'h77, 0, 1, 0, 1, 0);
        step(1'b1, 8'h88, 0, 0, 0, 0, 0);
        step(1'b1, 8'h99, 1, 0, 0, 0, 1);

        // Random mixed traffic
        for (int i = 0; i < 3000; i++) begin
            tx_hold_empty = ($urandom_range(0, 3) != 0);
            tx_shift_idle = ($urandom_range(0, 1) == 0);
            if ($urandom_range(0, 1) == 0) rand_push($urandom_range(0, 2) == 0, $urandom_range(0, 9) == 0);
            else step(1'b0, 8'h00, 0, 0, 0, $urandom_range(0, 1) == 0, $urandom_range(0, 5) == 0);
        end

        // Drain with reads
        repeat (DEPTH + 2) step(1'b0, 8'h00, 0, 0, 0, 1'b1, 1'b1);
        check("R6 error bit clear when drained", {7'd0, line_status[7]}, 8'h00);
        check("R4 empty after drain", {7'd0, line_status[0]}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule